// File: doc/BRIEF.md
# Late-Write Memory Front End with Byte Forwarding

This block is a synchronous front end for an on-chip word array of four 9-bit lanes. Address and control for every cycle are sampled on the rising clock edge. The data for a write is not supplied with its address. It arrives one edge later, so a write can follow a read on a shared data bus without a turnaround cycle.

A write that has been issued is held in a single pending entry made of an address, a lane mask and data. The entry reaches the array only when the next non-aborted write is issued. Reads compare their address with the pending entry. On a match, each lane that the pending write enabled comes from the entry and every other lane comes from the array. Read data is registered. It is qualified by an output-enable indication, which an asynchronous active-low enable input can suppress at any moment.

Top module: `lw_sram_front`

## Requirements
- R1: A read sampled at rising edge t shows its word on `dout_o`, with `dout_en_o` high, during the cycle that follows edge t+1, and only in that cycle.
- R2: The data for a write sampled at edge t is taken from `din_i` at edge t+1. `din_i` at any other edge has no effect on stored or returned data.
- R3: The data of a write is placed in the array when the next non-aborted write is issued, even if any number of reads or idle cycles come in between. A read of an address that has no pending write returns the array contents.
- R4: When a read address equals the pending write address, each lane that the pending write enabled comes from the pending data and the other lanes come from the array. This also holds for a read issued in the cycle right after the write.
- R5: Cycle encoding: with `desel_i` high the cycle is idle. With `desel_i` low, `wr_n_i` low is a write and `wr_n_i` high is a read. `bw_n_i[b]` low enables lane b, which is bits 9b to 9b+8.
- R6: A write with all four `bw_n_i` bits high is an abort. It changes no array word and leaves the pending entry, including its data, unchanged.
- R7: Outside the return cycle of a read, `dout_en_o` is low and `dout_o` is zero. This covers write, abort and idle cycles.
- R8: `oe_n_i` high forces `dout_en_o` low and `dout_o` to zero in the same cycle, without waiting for a clock edge.
- R9: While `rst` is high `dout_en_o` is low, and reset discards the pending entry. Words committed before the reset keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input except `oe_n_i` is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | Word address |
| desel_i | input | 1 | High makes the cycle idle |
| wr_n_i | input | 1 | Low selects a write, high a read |
| bw_n_i | input | LANES | Active-low lane enables for a write |
| din_i | input | LANES*LANE_W | Write data, one cycle after the write's address |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| dout_o | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en_o | output | 1 | High when `dout_o` is driven; low stands for high impedance |

## Verification
The bench builds the block with its default parameters: a 4-bit address (16 words) and four 9-bit lanes. These values let it fill the whole array first, so every later read of any address has a known value. They also let a 400-cycle random stream hit the pending address, and single lanes of it, often. Because there are four lanes, each lane enable can be tested on its own, as well as the partial masks and the all-disabled abort.

// File: rtl/lw_pkg.sv
package lw_pkg;
  // Kind of access presented on the input pins in one cycle.
  typedef enum logic [1:0] {
    CK_IDLE  = 2'd0,
    CK_READ  = 2'd1,
    CK_WRITE = 2'd2,
    CK_ABORT = 2'd3
  } cyc_kind_e;

  function automatic cyc_kind_e decode_kind(input logic desel, input logic wr_n,
                                            input logic no_lane);
    if (desel)   return CK_IDLE;
    if (wr_n)    return CK_READ;
    if (no_lane) return CK_ABORT;
    return CK_WRITE;
  endfunction
endpackage

// File: rtl/lw_array.sv
// Word array with per-lane write enables and a registered read port,
// shaped so that a block RAM with byte enables can be inferred.
module lw_array #(
  parameter int AW     = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    re,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int DW    = LANES * LANE_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int b = 0; b < LANES; b++) begin
      if (we[b]) mem[waddr][b*LANE_W +: LANE_W] <= wdata[b*LANE_W +: LANE_W];
    end
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lw_hold.sv
// Pending-write entry: address and mask are captured with the write,
// data one edge later; the entry is retired on the next real write.
module lw_hold
  import lw_pkg::*;
#(
  parameter int AW     = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  cyc_kind_e               kind_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [LANES-1:0]        bw_n_i,
  input  logic [LANES*LANE_W-1:0] din_i,
  output logic                    h_vld_o,
  output logic [AW-1:0]           h_addr_o,
  output logic [LANES-1:0]        h_mask_o,
  output logic [LANES*LANE_W-1:0] h_data_o,
  output logic [LANES-1:0]        cm_we_o,
  output logic [AW-1:0]           cm_addr_o,
  output logic [LANES*LANE_W-1:0] cm_data_o
);
  localparam int DW = LANES * LANE_W;

  logic            h_vld;
  logic [AW-1:0]   h_addr;
  logic [LANES-1:0] h_mask;
  logic [DW-1:0]   h_data;
  logic            data_due;   // the previous edge took a real write
  logic            take;

  assign take = (kind_i == CK_WRITE);

  // Retire the entry; when writes are back to back its data is still on din_i.
  assign cm_we_o   = (take && h_vld) ? h_mask : '0;
  assign cm_addr_o = h_addr;
  assign cm_data_o = data_due ? din_i : h_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_vld    <= 1'b0;
      h_addr   <= '0;
      h_mask   <= '0;
      h_data   <= '0;
      data_due <= 1'b0;
    end else begin
      data_due <= take;
      if (data_due) h_data <= din_i;
      if (take) begin
        h_vld  <= 1'b1;
        h_addr <= addr_i;
        h_mask <= ~bw_n_i;
      end
    end
  end

  assign h_vld_o  = h_vld;
  assign h_addr_o = h_addr;
  assign h_mask_o = h_mask;
  assign h_data_o = h_data;

  // R6: an aborted write leaves the pending entry untouched
  a_r6_abort_holds: assert property (@(posedge clk) disable iff (rst)
    (kind_i == CK_ABORT) |=> ($stable(h_addr) && $stable(h_mask) && $stable(h_vld)));

  // R2: the entry's data is the din_i sampled one edge after the write
  a_r2_data_follows: assert property (@(posedge clk) disable iff (rst)
    (kind_i == CK_WRITE) |-> ##2 (h_data == $past(din_i)));
endmodule

// File: rtl/lw_merge.sv
// Lane-wise forwarding from the pending entry, output register and
// asynchronous output gating.
module lw_merge #(
  parameter int AW     = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [LANES*LANE_W-1:0] arr_i,
  input  logic                    h_vld_i,
  input  logic [AW-1:0]           h_addr_i,
  input  logic [LANES-1:0]        h_mask_i,
  input  logic [LANES*LANE_W-1:0] h_data_i,
  input  logic                    oe_n_i,
  output logic [LANES*LANE_W-1:0] dout_o,
  output logic                    dout_en_o
);
  localparam int DW = LANES * LANE_W;

  logic          hit;
  logic [DW-1:0] merged;
  logic          o_vld;
  logic [DW-1:0] o_data;

  assign hit = h_vld_i && (addr_i == h_addr_i);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign merged[b*LANE_W +: LANE_W] = (hit && h_mask_i[b]) ? h_data_i[b*LANE_W +: LANE_W]
                                                              : arr_i[b*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld  <= 1'b0;
      o_data <= '0;
    end else begin
      o_vld <= rd_i;
      if (rd_i) o_data <= merged;
    end
  end

  assign dout_en_o = o_vld && !oe_n_i;
  assign dout_o    = dout_en_o ? o_data : '0;

  // R8: a high output enable never lets data out
  a_r8_oe_blocks: assert property (@(posedge clk) disable iff (rst)
    oe_n_i |-> (!dout_en_o && (dout_o == '0)));
endmodule

// File: rtl/lw_sram_front.sv
module lw_sram_front
  import lw_pkg::*;
#(
  parameter int AW     = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [AW-1:0]           addr_i,
  input  logic                    desel_i,
  input  logic                    wr_n_i,
  input  logic [LANES-1:0]        bw_n_i,
  input  logic [LANES*LANE_W-1:0] din_i,
  input  logic                    oe_n_i,
  output logic [LANES*LANE_W-1:0] dout_o,
  output logic                    dout_en_o
);
  localparam int DW = LANES * LANE_W;

  cyc_kind_e        kind;
  logic             s_rd;
  logic [AW-1:0]    s_addr;
  logic             h_vld;
  logic [AW-1:0]    h_addr;
  logic [LANES-1:0] h_mask;
  logic [DW-1:0]    h_data;
  logic [LANES-1:0] cm_we;
  logic [AW-1:0]    cm_addr;
  logic [DW-1:0]    cm_data;
  logic [DW-1:0]    arr_q;

  assign kind = decode_kind(desel_i, wr_n_i, &bw_n_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      s_rd   <= 1'b0;
      s_addr <= '0;
    end else begin
      s_rd   <= (kind == CK_READ);
      s_addr <= addr_i;
    end
  end

  lw_hold #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_hold (
    .clk(clk), .rst(rst), .kind_i(kind), .addr_i(addr_i), .bw_n_i(bw_n_i),
    .din_i(din_i), .h_vld_o(h_vld), .h_addr_o(h_addr), .h_mask_o(h_mask),
    .h_data_o(h_data), .cm_we_o(cm_we), .cm_addr_o(cm_addr), .cm_data_o(cm_data)
  );

  lw_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we(cm_we), .waddr(cm_addr), .wdata(cm_data),
    .re(kind == CK_READ), .raddr(addr_i), .rdata(arr_q)
  );

  lw_merge #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .clk(clk), .rst(rst), .rd_i(s_rd), .addr_i(s_addr), .arr_i(arr_q),
    .h_vld_i(h_vld), .h_addr_i(h_addr), .h_mask_i(h_mask), .h_data_i(h_data),
    .oe_n_i(oe_n_i), .dout_o(dout_o), .dout_en_o(dout_en_o)
  );

  // R1: a read is returned exactly two edges after it is sampled
  a_r1_read_shows: assert property (@(posedge clk) disable iff (rst)
    (!desel_i && wr_n_i) |-> ##2 (dout_en_o == !oe_n_i));

  // R7: write, abort and idle cycles never produce driven data
  a_r7_hiz_nonread: assert property (@(posedge clk) disable iff (rst)
    (desel_i || !wr_n_i) |-> ##2 !dout_en_o);

  // R3: the array is written only while a real write is on the pins
  a_r3_commit_on_write: assert property (@(posedge clk) disable iff (rst)
    (|cm_we) |-> (!desel_i && !wr_n_i && !(&bw_n_i)));
endmodule

// File: tb/sim_lw_sram_front.sv
module sim_lw_sram_front;
  localparam int AW = 4, LANES = 4, LANE_W = 9;
  localparam int DW = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0]    addr_i = '0;
  logic             desel_i = 1'b1;
  logic             wr_n_i = 1'b1;
  logic [LANES-1:0] bw_n_i = '1;
  logic [DW-1:0]    din_i = '0;
  logic             oe_n_i = 1'b0;
  logic [DW-1:0]    dout_o;
  logic             dout_en_o;

  lw_sram_front #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u0 (
    .clk(clk), .rst(rst), .addr_i(addr_i), .desel_i(desel_i), .wr_n_i(wr_n_i),
    .bw_n_i(bw_n_i), .din_i(din_i), .oe_n_i(oe_n_i), .dout_o(dout_o), .dout_en_o(dout_en_o)
  );

  always #10 clk = ~clk;   // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int            due;
    logic [DW-1:0] val;
    string         tag;
  } exp_t;
  exp_t q[$];

  // Reference: a plain coherent memory, plus its state before the last real write.
  logic [DW-1:0] ref_m [DEPTH];
  logic [DW-1:0] ref_keep [DEPTH];
  logic          prev_wr = 1'b0;
  logic [DW-1:0] prev_data = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 idle, 1 read, 2 write
  task automatic step(input int kind, input int a, input logic [3:0] bw,
                      input logic [DW-1:0] d, input string tag, input logic oe = 1'b0);
    @(negedge clk); #1;
    din_i   = prev_wr ? prev_data : DW'({$urandom, $urandom});
    prev_wr = 1'b0;
    oe_n_i  = oe;
    addr_i  = AW'(a);
    bw_n_i  = LANES'($urandom);
    wr_n_i  = 1'($urandom);
    desel_i = 1'b1;
    if (kind == 1) begin
      desel_i = 1'b0;
      wr_n_i  = 1'b1;
      q.push_back('{cyc + 2, ref_m[a], tag});
    end else if (kind == 2) begin
      desel_i = 1'b0;
      wr_n_i  = 1'b0;
      bw_n_i  = bw;
      if (bw != 4'hf) begin
        ref_keep = ref_m;
        for (int b = 0; b < LANES; b++)
          if (!bw[b]) ref_m[a][b*LANE_W +: LANE_W] = d[b*LANE_W +: LANE_W];
        prev_wr   = 1'b1;
        prev_data = d;
      end
    end
  endtask

  // Monitor: pops the scoreboard in the cycle each read is due.
  always @(negedge clk) begin
    exp_t it;
    if (rst) begin
      chk("R9 output enable low in reset", 64'(dout_en_o), 64'd0);
    end else if (q.size() > 0 && q[0].due == cyc) begin
      it = q.pop_front();
      if (oe_n_i) begin
        chk({"R8 enable held off: ", it.tag}, 64'(dout_en_o), 64'd0);
        chk({"R8 data zero: ", it.tag}, 64'(dout_o), 64'd0);
      end else begin
        chk({"R1 enable on return: ", it.tag}, 64'(dout_en_o), 64'd1);
        chk(it.tag, 64'(dout_o), 64'(it.val));
      end
    end else begin
      chk("R7 enable low outside return", 64'(dout_en_o), 64'd0);
      chk("R7 data zero outside return", 64'(dout_o), 64'd0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;

    // R3/R5: fill every word with full-lane writes, then one extra to retire the last
    for (int a = 0; a < DEPTH; a++) step(2, a, 4'h0, DW'({$urandom, $urandom}), "fill");
    step(2, 0, 4'h0, ref_m[0], "fill");
    for (int a = 0; a < DEPTH; a++) step(1, a, 4'h0, '0, "R3 array readback");

    // R4/R2: read right after write, same address
    step(2, 5, 4'h0, 36'h9_8765_4321, "w");
    step(1, 5, 4'h0, '0, "R4 read right after write");
    step(1, 5, 4'h0, '0, "R2 read again from pending entry");

    // R4/R5: partial mask, lanes 0 and 2 enabled (bw_n = 1010)
    step(2, 7, 4'b1010, 36'hA_BCDE_F012, "w");
    step(1, 7, 4'h0, '0, "R4 lane merge lanes 0 and 2");
    step(2, 9, 4'h0, 36'h1_1111_1111, "w");
    step(1, 7, 4'h0, '0, "R3 merged word after retire");
    step(1, 9, 4'h0, '0, "R4 pending full word");

    // R5: each lane alone
    for (int b = 0; b < LANES; b++) begin
      step(2, 3, ~(4'(1) << b), DW'({$urandom, $urandom}), "w");
      step(1, 3, 4'h0, '0, "R5 single lane enable");
    end

    // R6: abort keeps pending entry and array
    step(2, 10, 4'h0, 36'h5_5AA5_5AA5, "w");
    step(2, 10, 4'hf, 36'hF_FFFF_FFFF, "abort");
    step(1, 10, 4'h0, '0, "R6 pending kept after abort");
    step(2, 11, 4'h0, 36'h0_0F0F_0F0F, "w");
    step(1, 10, 4'h0, '0, "R6 aborted data never stored");

    // R3: reads and idles between writes
    step(2, 12, 4'h0, 36'hC_0FFE_E123, "w");
    step(1, 1, 4'h0, '0, "R3 unrelated read");
    step(0, 0, 4'h0, '0, "idle");
    step(1, 12, 4'h0, '0, "R4 pending after gap");
    step(2, 13, 4'h0, 36'h3_3333_3333, "w");
    step(1, 12, 4'h0, '0, "R3 first write after reads retires entry");

    // R8: output enable high over a read's return cycle
    step(1, 4, 4'h0, '0, "R8 read under oe");
    step(0, 0, 4'h0, '0, "idle", 1'b1);
    step(0, 0, 4'h0, '0, "idle", 1'b0);
    @(negedge clk); #5;
    oe_n_i = 1'b1;
    #1 chk("R8 enable off mid-cycle", 64'(dout_en_o), 64'd0);
    oe_n_i = 1'b0;

    // R9: reset discards the pending word, committed words stay
    step(2, 2, 4'h0, 36'h7_7777_7777, "w");
    step(0, 0, 4'h0, '0, "idle");
    step(0, 0, 4'h0, '0, "idle");
    step(0, 0, 4'h0, '0, "idle");
    @(negedge clk); #1 rst = 1'b1;
    ref_m   = ref_keep;
    prev_wr = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst = 1'b0;
    step(1, 2, 4'h0, '0, "R9 pending word dropped by reset");
    step(1, 13, 4'h0, '0, "R9 committed word kept");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      v = DW'({$urandom, $urandom});
      step(int'($urandom % 3), int'($urandom % DEPTH), 4'($urandom), v,
           "R4 random stream", ($urandom % 8) == 0);
    end
    repeat (4) step(0, 0, 4'h0, '0, "drain");
    chk("R1 every read returned", 64'(q.size()), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule